// File: doc/BRIEF.md
# Latched-Address SRAM Cycle Controller

This controller sits between a synchronous host and an asynchronous static RAM that captures its address on the falling edge of an active-low chip enable. The host hands over one request at a time: an address, a read/write flag and, for writes, a data word. The controller then runs one complete memory cycle. Every phase of that cycle lasts a fixed number of system clocks, set by parameters. The phases are address setup, enable-low address hold, write strobe or output turn-on, data valid, write-data hold and enable-high recovery.

The address is presented before the enable falls and is held for the hold interval after it falls. After that the address lines are released to zero. For a read, the output is first allowed to turn on. Data is captured only in the last clock of the valid phase, and the write strobe stays high for the whole cycle. For a write, the data bus is driven only while the write strobe is low. The strobe and the enable rise together, the data stays on the bus for a hold interval and the bus is then released. A recovery interval with the enable high always separates two cycles. The host sees a one-clock acknowledge when the enable returns high, with the read data registered on that clock.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is asserted, and afterwards, mem_ce_n=1, mem_we_n=1, mem_dq_oe=0, ack=0 and req_ready=0. req_ready first goes to 1 exactly RECOV_CLK clocks after reset is released.
- R2: A request is taken only on a clock edge where req_ready=1 and req_valid=1. req_ready is 0 from the next edge until the cycle is finished. Changes on req_valid, req_write, req_addr or req_wdata during a cycle have no effect on that cycle.
- R3: mem_addr carries the accepted address for SETUP_CLK clocks with mem_ce_n=1, then for HOLD_CLK clocks with mem_ce_n=0. In every other clock it is all zeros.
- R4: In a read, mem_we_n=1 and mem_dq_oe=0 for as long as mem_ce_n=0. mem_ce_n stays 0 for HOLD_CLK+OEN_CLK+VALID_CLK clocks. rdata takes the mem_dq_i value from the last clock of the valid phase.
- R5: In a write, mem_we_n is 0 for WSTB_CLK clocks directly after the hold phase. During those clocks mem_dq_oe=1 and mem_dq_o carries the accepted write data. mem_we_n and mem_ce_n rise on the same edge. mem_dq_oe stays 1, with the same data, for WDHOLD_CLK further clocks and then goes to 0.
- R6: mem_dq_oe is never 1 while mem_ce_n=0 and mem_we_n=1.
- R7: Between two cycles mem_ce_n stays high for at least RECOV_CLK clocks. For requests issued as early as possible, the high interval is at least RECOV_CLK+SETUP_CLK+1 clocks.
- R8: ack is never high for two clocks in a row. rdata changes only on a read acknowledge.
- R9: ack rises SETUP_CLK+HOLD_CLK+OEN_CLK+VALID_CLK clocks after the accepting edge for a read, and SETUP_CLK+HOLD_CLK+WSTB_CLK clocks after it for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Controller idle, a request is taken on this edge |
| ack | output | 1 | One-clock pulse at cycle end |
| rdata | output | DATA_W | Registered read data |
| mem_ce_n | output | 1 | Active-low chip enable, address captured on its fall |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq_o | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable of the data bus, 0 = high impedance |
| mem_dq_i | input | DATA_W | Data returned by the memory |

## Verification
The main function is exercised with a sequence of writes and reads to the lowest address, the highest address and alternating-bit addresses. The sequence also reads a location that was never written and overwrites a word and reads it back. This separates correct address latching and data capture from stuck or swapped bits. Each request is issued the moment req_ready returns, so the enable-high gap is measured at its minimum. During each cycle the request inputs are driven with inverted values, which exposes any re-capture while busy. A memory model in the bench returns a marker value until the access time computed from the phase lengths has passed, so an early read sample yields the marker instead of the stored word. A reset in the middle of a cycle checks that the memory side is deselected at once and that the recovery interval starts over.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_RECOV = 3'd0,
        ST_IDLE  = 3'd1,
        ST_SETUP = 3'd2,
        ST_HOLD  = 3'd3,
        ST_OEN   = 3'd4,
        ST_VALID = 3'd5,
        ST_WSTB  = 3'd6,
        ST_WHOLD = 3'd7
    } cyc_st_e;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Enable is low in these phases.
    function automatic logic ce_active(cyc_st_e s);
        return (s == ST_HOLD) || (s == ST_OEN) || (s == ST_VALID) || (s == ST_WSTB);
    endfunction

    // Controller drives the data bus in these phases.
    function automatic logic bus_driven(cyc_st_e s);
        return (s == ST_WSTB) || (s == ST_WHOLD);
    endfunction

endpackage

// File: rtl/phase_timer.sv
module phase_timer #(
    parameter int CNT_W   = 4,
    parameter int RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(RST_VAL);
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 8,
    parameter int SETUP_CLK  = 2,
    parameter int HOLD_CLK   = 1,
    parameter int OEN_CLK    = 1,
    parameter int VALID_CLK  = 2,
    parameter int RECOV_CLK  = 3,
    parameter int WSTB_CLK   = 2,
    parameter int WDHOLD_CLK = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);

    localparam int unsigned MAX_LEN = max2(max2(max2(SETUP_CLK, HOLD_CLK), max2(OEN_CLK, VALID_CLK)),
                                           max2(max2(RECOV_CLK, WSTB_CLK), WDHOLD_CLK));
    localparam int CNT_W = $clog2(MAX_LEN + 1);

    localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CLK - 1);
    localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(HOLD_CLK - 1);
    localparam logic [CNT_W-1:0] LD_OEN   = CNT_W'(OEN_CLK - 1);
    localparam logic [CNT_W-1:0] LD_VALID = CNT_W'(VALID_CLK - 1);
    localparam logic [CNT_W-1:0] LD_RECOV = CNT_W'(RECOV_CLK - 1);
    localparam logic [CNT_W-1:0] LD_WSTB  = CNT_W'(WSTB_CLK - 1);
    localparam logic [CNT_W-1:0] LD_WDH   = CNT_W'(WDHOLD_CLK - 1);

    generate
        if (SETUP_CLK < 1 || HOLD_CLK < 1 || OEN_CLK < 1 || VALID_CLK < 1 ||
            RECOV_CLK < 1 || WSTB_CLK < 1 || WDHOLD_CLK < 1) begin : g_bad_len
            $error("every phase length must be at least one clock");
        end
    endgenerate

    typedef struct packed {
        cyc_st_e           st;
        logic              is_wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic [ADDR_W-1:0] maddr;
        logic              ce_n;
        logic              we_n;
        logic              oe;
        logic              ack;
        logic              ready;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        st:    ST_RECOV,
        is_wr: 1'b0,
        addr:  '0,
        wdata: '0,
        rdata: '0,
        maddr: '0,
        ce_n:  1'b1,
        we_n:  1'b1,
        oe:    1'b0,
        ack:   1'b0,
        ready: 1'b0
    };

    ctl_t             r_d, r_q;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_done;

    phase_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (RECOV_CLK - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    always_comb begin
        r_d     = r_q;
        r_d.ack = 1'b0;
        t_load  = 1'b0;
        t_val   = '0;

        unique case (r_q.st)
            ST_RECOV: begin
                if (t_done) r_d.st = ST_IDLE;
            end
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st    = ST_SETUP;
                    r_d.is_wr = req_write;
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    t_load    = 1'b1;
                    t_val     = LD_SETUP;
                end
            end
            ST_SETUP: begin
                if (t_done) begin
                    r_d.st = ST_HOLD;
                    t_load = 1'b1;
                    t_val  = LD_HOLD;
                end
            end
            ST_HOLD: begin
                if (t_done) begin
                    t_load = 1'b1;
                    if (r_q.is_wr) begin
                        r_d.st = ST_WSTB;
                        t_val  = LD_WSTB;
                    end else begin
                        r_d.st = ST_OEN;
                        t_val  = LD_OEN;
                    end
                end
            end
            ST_OEN: begin
                if (t_done) begin
                    r_d.st = ST_VALID;
                    t_load = 1'b1;
                    t_val  = LD_VALID;
                end
            end
            ST_VALID: begin
                if (t_done) begin
                    r_d.st    = ST_RECOV;
                    r_d.rdata = mem_dq_i;
                    r_d.ack   = 1'b1;
                    t_load    = 1'b1;
                    t_val     = LD_RECOV;
                end
            end
            ST_WSTB: begin
                if (t_done) begin
                    r_d.st  = ST_WHOLD;
                    r_d.ack = 1'b1;
                    t_load  = 1'b1;
                    t_val   = LD_WDH;
                end
            end
            ST_WHOLD: begin
                if (t_done) begin
                    r_d.st = ST_RECOV;
                    t_load = 1'b1;
                    t_val  = LD_RECOV;
                end
            end
            default: r_d.st = ST_RECOV;
        endcase

        // Pin values follow the next phase so every output leaves a flop.
        r_d.ce_n  = !ce_active(r_d.st);
        r_d.we_n  = (r_d.st != ST_WSTB);
        r_d.oe    = bus_driven(r_d.st);
        r_d.ready = (r_d.st == ST_IDLE);
        r_d.maddr = ((r_d.st == ST_SETUP) || (r_d.st == ST_HOLD)) ? r_d.addr : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= CTL_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = r_q.ready;
    assign ack       = r_q.ack;
    assign rdata     = r_q.rdata;
    assign mem_ce_n  = r_q.ce_n;
    assign mem_we_n  = r_q.we_n;
    assign mem_addr  = r_q.maddr;
    assign mem_dq_o  = r_q.wdata;
    assign mem_dq_oe = r_q.oe;

endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk #(
    parameter int ADDR_W    = 10,
    parameter int RECOV_CLK = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              ack,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_dq_oe
);

    logic [15:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= '0;
        end else if (!mem_ce_n) begin
            hi_cnt <= '0;
        end else if (hi_cnt != 16'hFFFF) begin
            hi_cnt <= hi_cnt + 16'd1;
        end
    end

    // R7
    recovery_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n) |-> (hi_cnt >= 16'(RECOV_CLK)));

    // R3
    addr_latch_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n) |-> $stable(mem_addr));

    // R6
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_ce_n && mem_we_n));

    // R5
    strobe_inside_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_dq_oe));

    // R5
    strobe_enable_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> $rose(mem_ce_n));

    // R8
    ack_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R2
    ack_not_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !req_ready);

endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .RECOV_CLK (RECOV_CLK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .ack       (ack),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_addr  (mem_addr),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/test_sram_cycle_ctrl.sv
`timescale 1ns/1ps
module test_sram_cycle_ctrl;

    localparam int AW = 10;
    localparam int DW = 8;
    localparam int S  = 2;
    localparam int H  = 1;
    localparam int O  = 1;
    localparam int V  = 2;
    localparam int R  = 3;
    localparam int W  = 2;
    localparam int D  = 1;
    localparam int NV = 11;

    // {write, address, data (write data or expected read data)}
    localparam logic [AW+DW:0] VECS [0:NV-1] = '{
        {1'b1, 10'h010, 8'hA5},
        {1'b1, 10'h3FF, 8'h5A},
        {1'b1, 10'h000, 8'hC3},
        {1'b0, 10'h010, 8'hA5},
        {1'b0, 10'h3FF, 8'h5A},
        {1'b0, 10'h000, 8'hC3},
        {1'b0, 10'h155, 8'h00},
        {1'b1, 10'h010, 8'h0F},
        {1'b0, 10'h010, 8'h0F},
        {1'b1, 10'h2AA, 8'h99},
        {1'b0, 10'h2AA, 8'h99}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, ack;
    logic [DW-1:0] rdata;
    logic          mem_ce_n, mem_we_n, mem_dq_oe;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_o, mem_dq_i;

    int tests = 0;
    int fails = 0;
    int contention = 0;
    logic [DW-1:0] last_rd = '0;

    always #10 clk = ~clk;

    sram_cycle_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .SETUP_CLK(S), .HOLD_CLK(H), .OEN_CLK(O),
        .VALID_CLK(V), .RECOV_CLK(R), .WSTB_CLK(W), .WDHOLD_CLK(D)
    ) i_sram_cycle_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .ack(ack), .rdata(rdata), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
        .mem_dq_i(mem_dq_i)
    );

    // Asynchronous memory model: address taken on enable fall, access time in clocks.
    logic [DW-1:0] ram [0:(1<<AW)-1];
    logic [AW-1:0] lat_addr = '0;
    int            low_cnt = 0;

    always @(negedge mem_ce_n) lat_addr <= mem_addr;
    always @(posedge mem_we_n) if (mem_dq_oe) ram[lat_addr] <= mem_dq_o;
    always @(posedge clk) low_cnt <= mem_ce_n ? 0 : low_cnt + 1;
    assign mem_dq_i = (!mem_ce_n && mem_we_n && low_cnt >= H + O + V - 1) ? ram[lat_addr] : 8'hEE;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Enable-high gap and bus contention monitor.
    int  hi_cnt = 0;
    logic prev_ce = 1'b1;
    always @(negedge clk) begin
        if (!rst_n) begin
            hi_cnt = 0;
        end else begin
            if (mem_dq_oe && !mem_ce_n && mem_we_n) contention++;
            if (mem_ce_n) begin
                hi_cnt++;
            end else begin
                if (prev_ce) chk(hi_cnt >= R + S + 1, "R7 enable-high gap", hi_cnt, R + S + 1);
                hi_cnt = 0;
            end
        end
        prev_ce = mem_ce_n;
    end

    task automatic do_req(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        int lat;
        lat = wr ? (S + H + W) : (S + H + O + V);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        @(posedge clk);
        for (int n = 0; n <= lat + D + 1; n++) begin
            @(negedge clk);
            if (n == 0) begin
                // junk request while busy must be ignored
                req_addr  = ~a;
                req_wdata = ~d;
                req_write = ~wr;
                chk(!req_ready, "R2 ready low when busy", req_ready, 0);
            end
            if (n == lat - 1) req_valid = 1'b0;
            if (n == S - 1) chk(mem_ce_n && mem_addr == a, "R3 setup address", {mem_ce_n, mem_addr}, {1'b1, a});
            if (n == S + H - 1) chk(!mem_ce_n && mem_addr == a, "R3 hold address", {mem_ce_n, mem_addr}, {1'b0, a});
            if (n == S + H) chk(mem_addr == '0, "R3 address released", mem_addr, 0);
            if (wr) begin
                if (n == S + H) chk(!mem_we_n && mem_dq_oe && mem_dq_o == d, "R5 strobe and data",
                                    {mem_we_n, mem_dq_oe, mem_dq_o}, {2'b01, d});
                if (n == S + H + W - 1) chk(!mem_we_n, "R5 strobe width", mem_we_n, 0);
                if (n == lat) chk(mem_ce_n && mem_we_n && mem_dq_oe && mem_dq_o == d, "R5 data hold",
                                  {mem_ce_n, mem_we_n, mem_dq_oe, mem_dq_o}, {3'b111, d});
                if (n == lat + D) chk(!mem_dq_oe, "R5 bus released", mem_dq_oe, 0);
                if (n == lat) chk(rdata == last_rd, "R8 rdata kept on write", rdata, last_rd);
            end else begin
                if (n == S + H + O) chk(!mem_ce_n && mem_we_n && !mem_dq_oe, "R4 read strobe high",
                                        {mem_ce_n, mem_we_n, mem_dq_oe}, 3'b010);
                if (n == lat) begin
                    chk(rdata == d, "R4 read data", rdata, d);
                    last_rd = d;
                end
            end
            if (n == lat - 1) chk(!ack, "R9 ack not early", ack, 0);
            if (n == lat) chk(ack, "R9 ack latency", ack, 1);
            if (n == lat + 1) chk(!ack, "R8 ack one clock", ack, 0);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) ram[i] = '0;

        // R1: reset state and recovery before the first request
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_we_n && !mem_dq_oe && !ack && !req_ready, "R1 reset outputs",
            {mem_ce_n, mem_we_n, mem_dq_oe, ack, req_ready}, 5'b11000);
        rst_n = 1'b1;
        for (int k = 1; k <= R; k++) begin
            @(negedge clk);
            if (k < R) chk(!req_ready && mem_ce_n, "R1 idle during recovery", {req_ready, mem_ce_n}, 2'b01);
            else       chk(req_ready, "R1 ready after recovery", req_ready, 1);
        end

        // Vector table: writes and reads, issued back to back
        for (int v = 0; v < NV; v++) begin
            do_req(VECS[v][AW+DW], VECS[v][AW+DW-1:DW], VECS[v][DW-1:0]);
        end

        // Reset in the middle of a read
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b0;
        req_addr  = 10'h3FF;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (S) @(negedge clk);
        chk(!mem_ce_n, "R4 enable low before reset", mem_ce_n, 0);
        rst_n = 1'b0;
        #1;
        chk(mem_ce_n && mem_we_n && !mem_dq_oe && !req_ready, "R1 mid-cycle reset",
            {mem_ce_n, mem_we_n, mem_dq_oe, req_ready}, 4'b1100);
        @(negedge clk);
        rst_n = 1'b1;
        last_rd = '0;
        repeat (R - 1) @(negedge clk);
        chk(!req_ready, "R1 recovery restarts", req_ready, 0);
        do_req(1'b0, 10'h2AA, 8'h99);

        chk(contention == 0, "R6 no bus contention", contention, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule